// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block turns an addressing-mode opcode, its one-byte offset and the current index value X into a 16-bit data-memory address for a small 8-bit controller. Three modes are handled: indirect through X, indirect through X with post-increment of X, and offset plus X. The high address byte normally comes from a page-select path: a global page flag chooses between page zero and a page register. The post-increment mode always goes to a fixed page, whatever the flag and register hold.

The sequencer presents the opcode with a qualifier strobe. One clock later the block presents the address, a valid strobe, the next X value and a write-enable for X. The post-increment writeback arrives on the same edge as the address it belongs to. Any other opcode produces no access and leaves X alone.

Top module: `dp_agen`

## Requirements
- R1: Opcode D4h (indirect) gives an address whose low byte equals X and whose high byte is the selected page.
- R2: The selected page is the page register when the page flag is 1, and 00h when the flag is 0.
- R3: Opcode C6h (offset plus X) gives the address (page × 256 + operand + X) mod 65536. The carry out of the low byte goes into the high byte, so operand 45h with X F5h and flag 0 gives 013Ah.
- R4: Opcode DBh (post-increment) gives the address 0100h + X, for any page flag and page register value.
- R5: With DBh, x_out is (X + 1) mod 256, so FFh becomes 00h. x_wr is 1 in the same cycle that addr_valid is 1.
- R6: If op_valid is 0, or the opcode is anything other than D4h, C6h or DBh, then addr_valid is 0, x_wr is 0, addr is 0000h and x_out equals X.
- R7: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: While rst_n is low, addr is 0000h, addr_valid is 0, x_wr is 0 and x_out is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies opcode and operand this cycle |
| opcode | input | 8 | Addressing-mode opcode |
| operand | input | 8 | Offset byte for the offset-plus-X mode |
| x_in | input | 8 | Current X index value |
| g_flag | input | 1 | Page flag: 1 selects the page register |
| page_reg | input | 8 | Page register value |
| addr | output | 16 | Effective data-memory address |
| addr_valid | output | 1 | Address is a real access |
| x_out | output | 8 | Next X value |
| x_wr | output | 1 | Write x_out back into X |

## Verification
The bench sweeps X through 00h, 01h, 7Fh, 80h, F5h, FEh and FFh, and the operand through 00h, 0Bh, 45h and FFh, under both page flag values and four page register values. Every mode opcode is tried, along with a neighbouring unused opcode and an unqualified cycle. The F5h and FFh offset cases show whether the offset sum carries into the high byte or wraps. Post-increment with page flag 1 and a nonzero page register shows whether the fixed page overrides page selection. X = FFh shows whether the increment wraps to 00h. Inputs are also changed between edges to show that the outputs are registered.

// File: rtl/dpag_pkg.sv
package dpag_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  typedef enum logic [1:0] {
    AM_NONE = 2'd0,
    AM_IND  = 2'd1,
    AM_DPX  = 2'd2,
    AM_PINC = 2'd3
  } amode_e;

  // page * 2^DW + off + x, truncated to AW bits (carry lands in high byte)
  function automatic logic [AW-1:0] dpx_sum(input logic [DW-1:0] page,
                                            input logic [DW-1:0] off,
                                            input logic [DW-1:0] x);
    logic [AW-1:0] base;
    base = {page, {DW{1'b0}}};
    return base + {{DW{1'b0}}, off} + {{DW{1'b0}}, x};
  endfunction

  function automatic logic [AW-1:0] page_join(input logic [DW-1:0] page,
                                              input logic [DW-1:0] low);
    return {page, low};
  endfunction

  function automatic logic [DW-1:0] x_step(input logic [DW-1:0] x);
    return x + {{(DW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/dpag_decode.sv
module dpag_decode
  import dpag_pkg::*;
#(
  parameter logic [DW-1:0] OPC_IND  = 8'hD4,
  parameter logic [DW-1:0] OPC_DPX  = 8'hC6,
  parameter logic [DW-1:0] OPC_PINC = 8'hDB
) (
  input  logic          op_valid,
  input  logic [DW-1:0] opcode,
  output amode_e        mode
);
  always_comb begin
    mode = AM_NONE;
    if (op_valid) begin
      if (opcode == OPC_IND)       mode = AM_IND;
      else if (opcode == OPC_DPX)  mode = AM_DPX;
      else if (opcode == OPC_PINC) mode = AM_PINC;
    end
  end
endmodule

// File: rtl/dpag_page_sel.sv
module dpag_page_sel
  import dpag_pkg::*;
#(
  parameter logic [DW-1:0] PINC_PAGE = 8'h01
) (
  input  amode_e        mode,
  input  logic          g_flag,
  input  logic [DW-1:0] page_reg,
  output logic [DW-1:0] page_hi
);
  logic [DW-1:0] flag_page;
  assign flag_page = g_flag ? page_reg : {DW{1'b0}};

  always_comb begin
    unique case (mode)
      AM_PINC: page_hi = PINC_PAGE;
      AM_IND,
      AM_DPX:  page_hi = flag_page;
      default: page_hi = {DW{1'b0}};
    endcase
  end
endmodule

// File: rtl/dpag_xupd.sv
module dpag_xupd
  import dpag_pkg::*;
(
  input  amode_e        mode,
  input  logic [DW-1:0] x_in,
  output logic [DW-1:0] x_nxt,
  output logic          x_we
);
  assign x_we  = (mode == AM_PINC);
  assign x_nxt = x_we ? x_step(x_in) : x_in;
endmodule

// File: rtl/dp_agen.sv
module dp_agen
  import dpag_pkg::*;
#(
  parameter logic [7:0] OPC_IND   = 8'hD4,
  parameter logic [7:0] OPC_DPX   = 8'hC6,
  parameter logic [7:0] OPC_PINC  = 8'hDB,
  parameter logic [7:0] PINC_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  opcode,
  input  logic [7:0]  operand,
  input  logic [7:0]  x_in,
  input  logic        g_flag,
  input  logic [7:0]  page_reg,
  output logic [15:0] addr,
  output logic        addr_valid,
  output logic [7:0]  x_out,
  output logic        x_wr
);
  amode_e        mode;
  logic [DW-1:0] page_hi;
  logic [DW-1:0] x_nxt;
  logic          x_we;
  logic [AW-1:0] addr_d;
  logic          access_d;

  dpag_decode #(
    .OPC_IND (OPC_IND),
    .OPC_DPX (OPC_DPX),
    .OPC_PINC(OPC_PINC)
  ) u_decode (
    .op_valid(op_valid),
    .opcode  (opcode),
    .mode    (mode)
  );

  dpag_page_sel #(
    .PINC_PAGE(PINC_PAGE)
  ) u_page (
    .mode    (mode),
    .g_flag  (g_flag),
    .page_reg(page_reg),
    .page_hi (page_hi)
  );

  dpag_xupd u_xupd (
    .mode (mode),
    .x_in (x_in),
    .x_nxt(x_nxt),
    .x_we (x_we)
  );

  assign access_d = (mode != AM_NONE);

  always_comb begin
    unique case (mode)
      AM_IND,
      AM_PINC: addr_d = page_join(page_hi, x_in);
      AM_DPX:  addr_d = dpx_sum(page_hi, operand, x_in);
      default: addr_d = {AW{1'b0}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      addr_valid <= 1'b0;
      x_out      <= '0;
      x_wr       <= 1'b0;
    end else begin
      addr       <= addr_d;
      addr_valid <= access_d;
      x_out      <= x_nxt;
      x_wr       <= x_we;
    end
  end
endmodule

// File: rtl/dpag_checker.sv
module dpag_checker #(
  parameter logic [7:0] OPC_IND   = 8'hD4,
  parameter logic [7:0] OPC_DPX   = 8'hC6,
  parameter logic [7:0] OPC_PINC  = 8'hDB,
  parameter logic [7:0] PINC_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [7:0]  opcode,
  input logic [7:0]  operand,
  input logic [7:0]  x_in,
  input logic        g_flag,
  input logic [7:0]  page_reg,
  input logic [15:0] addr,
  input logic        addr_valid,
  input logic [7:0]  x_out,
  input logic        x_wr
);
  logic is_ind, is_dpx, is_pinc, is_none;
  assign is_ind  = op_valid && (opcode == OPC_IND);
  assign is_dpx  = op_valid && (opcode == OPC_DPX);
  assign is_pinc = op_valid && (opcode == OPC_PINC);
  assign is_none = !(is_ind || is_dpx || is_pinc);

  p_ind_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_ind |=> (addr_valid && addr[7:0] == $past(x_in)));

  p_page_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_ind |=> (addr[15:8] == ($past(g_flag) ? $past(page_reg) : 8'h00)));

  p_dpx_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dpx && !g_flag) |=>
      (addr == (16'($past(operand)) + 16'($past(x_in)))));

  p_pinc_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pinc |=> (addr == {PINC_PAGE, $past(x_in)}));

  p_pinc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pinc |=> (x_wr && addr_valid && x_out == 8'($past(x_in) + 8'd1)));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_none |=> (!addr_valid && !x_wr && addr == 16'h0 && x_out == $past(x_in)));

  p_wr_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    x_wr |-> addr_valid);
endmodule

bind dp_agen dpag_checker #(
  .OPC_IND  (OPC_IND),
  .OPC_DPX  (OPC_DPX),
  .OPC_PINC (OPC_PINC),
  .PINC_PAGE(PINC_PAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .operand   (operand),
  .x_in      (x_in),
  .g_flag    (g_flag),
  .page_reg  (page_reg),
  .addr      (addr),
  .addr_valid(addr_valid),
  .x_out     (x_out),
  .x_wr      (x_wr)
);

// File: tb/dp_agen_tb.sv
`timescale 1ns/1ps
module dp_agen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  opcode, operand, x_in, page_reg;
  logic        g_flag;
  logic [15:0] addr;
  logic        addr_valid;
  logic [7:0]  x_out;
  logic        x_wr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dp_agen u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .operand(operand), .x_in(x_in), .g_flag(g_flag), .page_reg(page_reg),
    .addr(addr), .addr_valid(addr_valid), .x_out(x_out), .x_wr(x_wr)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Behavioural reference: returns expected address, valid, x, write
  task automatic model(input bit v, input int op, input int opd, input int x,
                       input bit g, input int rp,
                       output int ea, output int ev, output int ex, output int ew,
                       output string tag);
    int page;
    page = g ? rp : 0;
    ea = 0; ev = 0; ex = x; ew = 0; tag = "R6";
    if (v && op == 'hD4) begin
      ea = page * 256 + x; ev = 1; tag = "R1 R2";
    end else if (v && op == 'hC6) begin
      ea = (page * 256 + opd + x) % 65536; ev = 1; tag = "R3";
    end else if (v && op == 'hDB) begin
      ea = 256 + x; ev = 1; ex = (x + 1) % 256; ew = 1; tag = "R4 R5";
    end
  endtask

  task automatic run_op(input bit v, input int op, input int opd, input int x,
                        input bit g, input int rp);
    int ea, ev, ex, ew;
    string tag;
    @(negedge clk);
    op_valid = v; opcode = 8'(op); operand = 8'(opd); x_in = 8'(x);
    g_flag = g; page_reg = 8'(rp);
    model(v, op, opd, x, g, rp, ea, ev, ex, ew, tag);
    @(posedge clk);
    #1;
    check({tag, " addr"},  int'(addr),       ea);
    check({tag, " valid"}, int'(addr_valid), ev);
    check({tag, " x_out"}, int'(x_out),      ex);
    check({tag, " x_wr"},  int'(x_wr),       ew);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int xs[7]  = '{'h00, 'h01, 'h7F, 'h80, 'hF5, 'hFE, 'hFF};
    int ods[4] = '{'h00, 'h0B, 'h45, 'hFF};
    int rps[4] = '{'h00, 'h01, 'h80, 'hFF};
    int ops[5] = '{'hD4, 'hC6, 'hDB, 'h00, 'hD5};
    rst_n = 1'b0; op_valid = 1'b1; opcode = 8'hDB; operand = 8'h45;
    x_in = 8'h35; g_flag = 1'b1; page_reg = 8'h01;
    repeat (2) @(posedge clk);
    #1;
    // R8: reset holds outputs at zero despite a valid op on the inputs
    check("R8 addr",  int'(addr), 0);
    check("R8 valid", int'(addr_valid), 0);
    check("R8 x_out", int'(x_out), 0);
    check("R8 x_wr",  int'(x_wr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Worked examples
    run_op(1, 'hD4, 0, 'h15, 1, 'h01);   // R2: 0115h
    check("R2 example", int'(addr), 'h0115);
    run_op(1, 'hC6, 'h45, 'hF5, 0, 'h00); // R3: 013Ah
    check("R3 example", int'(addr), 'h013A);
    run_op(1, 'hDB, 0, 'h35, 1, 'h80);   // R4: 0135h regardless of page
    check("R4 example", int'(addr), 'h0135);
    check("R5 example", int'(x_out), 'h36);
    run_op(1, 'hDB, 0, 'hFF, 0, 'h00);   // R5 wrap
    check("R5 wrap", int'(x_out), 'h00);
    run_op(0, 'hDB, 0, 'h22, 1, 'h01);   // R6 unqualified

    // R7: change inputs mid-cycle; outputs must not move before the edge
    @(negedge clk);
    op_valid = 1'b1; opcode = 8'hD4; x_in = 8'h77; g_flag = 1'b0;
    #1;
    check("R7 hold valid", int'(addr_valid), 0);
    check("R7 hold addr",  int'(addr), 0);
    @(posedge clk);
    #1;
    check("R7 update addr", int'(addr), 'h0077);

    // Sweep
    for (int o = 0; o < 5; o++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 4; j++)
          for (int gi = 0; gi < 2; gi++)
            for (int k = 0; k < 4; k++)
              run_op(1, ops[o], ods[j], xs[i], gi[0], rps[k]);
    for (int i = 0; i < 7; i++)
      run_op(0, 'hC6, 'h45, xs[i], 1, 'hFF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule